// File: doc/BRIEF.md
# Doorbell-Gated Sequence Launcher

This block holds a signed credit count that decides when a command execution unit may begin a queued command sequence. Software places one or more command sequences in a queue. Each sequence opens with a bus-acquire command and closes with a bus-release command. Software then rings the doorbell by adding a signed value to the count, usually the number of sequences it has just queued. Software can also sample the count at any time through a read strobe.

When the executor fetches a bus-acquire command, it raises a request and holds it. The launcher grants the request only if the count is positive and no stall is pending. Each grant removes one credit. If the count is zero or negative at the fetch, the launcher latches a stall. Only a software write with nonzero data clears that stall. The held request is then evaluated again against the updated count, and it proceeds only if the count has become positive.

Top module: `dbl_launcher`

## Requirements
- R1: Reset values: the count is 0, grant is low, stall is low and the read-valid output is low.
- R2: A doorbell write adds the 8-bit data to the count, reading the data as two's complement. For example, 8'hFD adds -3. The new count appears on `credit_o` in the cycle after the write.
- R3: A read strobe makes `rd_vld_o` high for one cycle in the next cycle. In that cycle `rd_data_o` holds the count as it stood in the strobe cycle.
- R4: `acq_grant_o` is high in the same cycle as a held request when the count is positive and no stall is latched. The count is one lower in the following cycle.
- R5: Suppose a request is held while the count is zero or negative and there is no nonzero write in that cycle. Then no grant is given, and `acq_stall_o` is high from the next cycle onward.
- R6: While a stall is latched, no grant is given. A write of zero, or no write at all, leaves the stall in place.
- R7: A nonzero write clears the stall in the next cycle. The held request is then evaluated again. It is granted if the count is now positive. If the count is still zero or negative, the stall is latched again one cycle later.
- R8: If a doorbell write and a grant fall in the same cycle, both take effect: the next count is the old count plus the data minus one.
- R9: With the default saturating variant, the count stays within -128 to +127 and does not wrap.
- R10: One write of N credits lets N back-to-back acquire requests through. The next request after those N stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr_i | input | 1 | Doorbell write strobe |
| db_wdata_i | input | 8 | Signed value to add to the count |
| db_rd_i | input | 1 | Count read strobe |
| acq_req_i | input | 1 | Bus-acquire fetch request, held until granted |
| acq_grant_o | output | 1 | Request may proceed; consumes one credit |
| acq_stall_o | output | 1 | A stall is latched for the held request |
| credit_o | output | 8 | Current signed count |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Count captured by the last read strobe |

## Verification
Grant is combinational, so the bench checks it in the same cycle as the request, after the inputs have settled. The count, the stall flag and the read data each pass through one register, so the bench compares them in the cycle after the stimulus that caused them. Every cycle, a bench model advances its count and stall state by one step and compares the registered outputs before it applies the next inputs. This holds the release-then-re-stall sequence to its exact cycles. Random doorbell values, including zero and negative values, are mixed with directed cases for saturation, simultaneous write and grant, and multi-credit batches.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
   parameter int unsigned DBL_DEF_W = 8;

   typedef enum logic {
      GATE_OPEN = 1'b0,
      GATE_HELD = 1'b1
   } gate_e;
endpackage

// File: rtl/dbl_cnt_update.sv
module dbl_cnt_update #(
   parameter int unsigned W   = dbl_pkg::DBL_DEF_W,
   parameter bit          SAT = 1'b1
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] add_i,
   input  logic         dec_i,
   output logic [W-1:0] nxt_o
);
   localparam int unsigned XW = W + 2;
   localparam logic signed [XW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
   localparam logic signed [XW-1:0] MINV = {3'b111, {(W-1){1'b0}}};

   logic signed [XW-1:0] sum;

   always_comb begin
      sum = $signed({{2{cur_i[W-1]}}, cur_i})
          + $signed({{2{add_i[W-1]}}, add_i})
          - $signed({{(XW-1){1'b0}}, dec_i});
   end

   generate
      if (SAT) begin : g_sat
         always_comb begin
            if (sum > MAXV)      nxt_o = MAXV[W-1:0];
            else if (sum < MINV) nxt_o = MINV[W-1:0];
            else                 nxt_o = sum[W-1:0];
         end
      end else begin : g_wrap
         assign nxt_o = sum[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/dbl_gate.sv
module dbl_gate #(
   parameter int unsigned W = dbl_pkg::DBL_DEF_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_i,
   input  logic [W-1:0] cnt_i,
   input  logic         wr_nz_i,
   output logic         grant_o,
   output logic         held_o
);
   import dbl_pkg::*;

   gate_e state_q, state_d;
   logic  positive;

   assign positive = ~cnt_i[W-1] & (|cnt_i);
   assign grant_o  = req_i & (state_q == GATE_OPEN) & positive;
   assign held_o   = (state_q == GATE_HELD);

   always_comb begin
      state_d = GATE_OPEN;
      if (req_i && !wr_nz_i && (state_q == GATE_HELD || !positive))
         state_d = GATE_HELD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= GATE_OPEN;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/dbl_launcher.sv
module dbl_launcher #(
   parameter int unsigned CNT_W = dbl_pkg::DBL_DEF_W,
   parameter bit          SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             db_wr_i,
   input  logic [CNT_W-1:0] db_wdata_i,
   input  logic             db_rd_i,
   input  logic             acq_req_i,
   output logic             acq_grant_o,
   output logic             acq_stall_o,
   output logic [CNT_W-1:0] credit_o,
   output logic             rd_vld_o,
   output logic [CNT_W-1:0] rd_data_o
);
   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("dbl_launcher: CNT_W must lie in 2..30");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_d, add_val;
   logic             wr_nz;

   assign add_val = db_wr_i ? db_wdata_i : '0;
   assign wr_nz   = db_wr_i & (|db_wdata_i);

   dbl_gate #(.W(CNT_W)) i_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (acq_req_i),
      .cnt_i   (cnt_q),
      .wr_nz_i (wr_nz),
      .grant_o (acq_grant_o),
      .held_o  (acq_stall_o)
   );

   dbl_cnt_update #(.W(CNT_W), .SAT(SAT)) i_upd (
      .cur_i (cnt_q),
      .add_i (add_val),
      .dec_i (acq_grant_o),
      .nxt_o (cnt_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         rd_vld_o  <= 1'b0;
         rd_data_o <= '0;
      end else begin
         cnt_q    <= cnt_d;
         rd_vld_o <= db_rd_i;
         if (db_rd_i) rd_data_o <= cnt_q;
      end
   end

   assign credit_o = cnt_q;
endmodule

// File: rtl/dbl_launcher_chk.sv
module dbl_launcher_chk #(
   parameter int unsigned CNT_W = dbl_pkg::DBL_DEF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             db_wr_i,
   input logic [CNT_W-1:0] db_wdata_i,
   input logic             db_rd_i,
   input logic             acq_req_i,
   input logic             acq_grant_o,
   input logic             acq_stall_o,
   input logic [CNT_W-1:0] credit_o,
   input logic             rd_vld_o,
   input logic [CNT_W-1:0] rd_data_o
);
   AST_GRANT_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      acq_grant_o |-> (acq_req_i && !credit_o[CNT_W-1] && credit_o != '0)); // R4
   AST_NO_GRANT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      acq_stall_o |-> !acq_grant_o); // R6
   AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_stall_o && acq_req_i && !(db_wr_i && db_wdata_i != '0)) |=> acq_stall_o); // R6
   AST_RELEASE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_stall_o && db_wr_i && db_wdata_i != '0) |=> !acq_stall_o); // R7
   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_grant_o && !db_wr_i) |=> credit_o == $past(credit_o) - 1'b1); // R4
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!db_wr_i && !acq_grant_o) |=> $stable(credit_o)); // R2
   AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      db_rd_i |=> (rd_vld_o && rd_data_o == $past(credit_o))); // R3
endmodule

bind dbl_launcher dbl_launcher_chk #(.CNT_W(CNT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .db_wr_i     (db_wr_i),
   .db_wdata_i  (db_wdata_i),
   .db_rd_i     (db_rd_i),
   .acq_req_i   (acq_req_i),
   .acq_grant_o (acq_grant_o),
   .acq_stall_o (acq_stall_o),
   .credit_o    (credit_o),
   .rd_vld_o    (rd_vld_o),
   .rd_data_o   (rd_data_o)
);

// File: tb/test_dbl_launcher.sv
`timescale 1ns/1ps
module test_dbl_launcher;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       db_wr_i = 1'b0;
   logic [7:0] db_wdata_i = '0;
   logic       db_rd_i = 1'b0;
   logic       acq_req_i = 1'b0;
   logic       acq_grant_o, acq_stall_o, rd_vld_o;
   logic [7:0] credit_o, rd_data_o;

   int n_checks = 0;
   int n_fail   = 0;
   int m_cnt    = 0;
   bit m_stall  = 0;
   bit m_vld    = 0;
   int m_rd     = 0;
   bit done     = 0;

   always #2.5 clk = ~clk;

   dbl_launcher i_dbl_launcher (.*);

   function automatic int clamp(input int v);
      if (v > 127)  return 127;
      if (v < -128) return -128;
      return v;
   endfunction

   function automatic int sx8(input logic [7:0] v);
      return int'($signed(v));
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, check settled outputs, advance model
   task automatic step(input bit we, input logic [7:0] wd, input bit re,
                       input bit aq, input string tag, output bit granted);
      bit eg, wnz;
      @(negedge clk);
      db_wr_i = we; db_wdata_i = wd; db_rd_i = re; acq_req_i = aq;
      #1;
      chk({tag, " credit"}, sx8(credit_o), m_cnt);
      chk({tag, " stall"}, int'(acq_stall_o), int'(m_stall));
      chk({tag, " R3 rd_vld"}, int'(rd_vld_o), int'(m_vld));
      if (m_vld) chk({tag, " R3 rd_data"}, sx8(rd_data_o), m_rd);
      eg  = aq && !m_stall && (m_cnt > 0);
      wnz = we && (wd != 8'h00);
      chk({tag, " grant"}, int'(acq_grant_o), int'(eg));
      m_vld = re;
      if (re) m_rd = m_cnt;
      m_stall = aq && !wnz && (m_stall || m_cnt <= 0);
      m_cnt = clamp(m_cnt + (we ? sx8(wd) : 0) - (eg ? 1 : 0));
      granted = eg;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit g;
      bit aq;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset credit", sx8(credit_o), 0);
      chk("R1 reset grant",  int'(acq_grant_o), 0);
      chk("R1 reset stall",  int'(acq_stall_o), 0);
      chk("R1 reset rd_vld", int'(rd_vld_o), 0);
      @(negedge clk); rst_n = 1'b1;

      // R5: request with zero credit stalls
      step(0, 8'h00, 0, 1, "R5", g);
      chk("R5 no grant at zero", int'(g), 0);
      step(0, 8'h00, 0, 1, "R5", g);
      // R6: zero write keeps stall
      step(1, 8'h00, 0, 1, "R6", g);
      step(0, 8'h00, 0, 1, "R6", g);
      chk("R6 held", int'(acq_stall_o), 1);
      // R7: nonzero negative write releases, re-stalls
      step(1, 8'hFD, 0, 1, "R7", g);  // -3
      step(0, 8'h00, 1, 1, "R7", g);  // released cycle, re-evaluate
      chk("R7 released", int'(acq_stall_o), 0);
      step(0, 8'h00, 0, 1, "R7", g);
      chk("R7 re-stall", int'(acq_stall_o), 1);
      // R2: add +6 -> 3, then R7 grant after release
      step(1, 8'h06, 0, 1, "R2", g);
      step(0, 8'h00, 0, 1, "R7", g);
      chk("R7 grant after release", int'(g), 1);
      step(0, 8'h00, 0, 0, "R4", g);
      chk("R4 credit after grant", sx8(credit_o), 2);
      // R10: batch of 3 more credits -> 5 back-to-back grants then stall
      step(1, 8'h03, 0, 0, "R10", g);
      for (int i = 0; i < 5; i++) begin
         step(0, 8'h00, 0, 1, "R10", g);
         chk("R10 batch grant", int'(g), 1);
      end
      step(0, 8'h00, 0, 1, "R10", g);
      chk("R10 stall after batch", int'(g), 0);
      step(1, 8'h01, 0, 0, "R7", g);
      // R8: write and grant together
      step(1, 8'h04, 0, 0, "R2", g);
      step(1, 8'h02, 0, 1, "R8", g);
      chk("R8 grant with write", int'(g), 1);
      step(0, 8'h00, 1, 0, "R8", g);
      chk("R8 credit sum", sx8(credit_o), 6);
      // R9: saturation both ways
      step(1, 8'h7F, 0, 0, "R9", g);
      step(1, 8'h7F, 0, 0, "R9", g);
      step(0, 8'h00, 0, 0, "R9", g);
      chk("R9 high clamp", sx8(credit_o), 127);
      step(1, 8'h80, 0, 0, "R9", g);
      step(1, 8'h80, 0, 0, "R9", g);
      step(1, 8'h80, 0, 0, "R9", g);
      step(0, 8'h00, 1, 0, "R9", g);
      chk("R9 low clamp", sx8(credit_o), -128);
      step(1, 8'h7F, 0, 0, "R2", g);
      step(1, 8'h81, 0, 0, "R2", g);

      // random phase
      aq = 0;
      for (int c = 0; c < 4000; c++) begin
         bit we = ($urandom % 4) == 0;
         logic [7:0] wd = 8'($urandom % 9) - 8'd3;
         bit re = ($urandom % 5) == 0;
         if (!aq) aq = ($urandom % 3) == 0;
         step(we, wd, re, aq, "R4 R5 R6 R7 R8 random", g);
         if (g) aq = 0;
      end
      step(0, 8'h00, 0, 0, "R2", g);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule